// File: doc/BRIEF.md
# Tagged Road Bypass Splitter

This block sits in a track-trigger road stream. Each road word carries a tag bit that marks roads whose tracks can skip the impact-parameter fit. The splitter buffers incoming words in a small FIFO and routes the head word by that tag. Tagged roads leave on an auxiliary bypass port toward a separate selection processor. Untagged roads stay on the regular port toward hit buffering and fitting, and tagged roads never appear there.

End-of-event markers are copied to both ports, so each consumer sees every event boundary, including events that carry no road for it. Both ports use valid/ready handshakes and accept words independently. The head word is removed only after every port that needs it has taken it. The block also keeps a count of tagged and untagged roads for each event, so the event's totals can be monitored.

Word layout: bit `WORD_W-1` is the end-of-event marker, bit `WORD_W-2` is the bypass tag, and the lower bits are payload that passes through unchanged.

Top module: `road_splitter`

## Requirements
- R1: A word with bit WORD_W-1 clear and bit WORD_W-2 set (a tagged road) is presented on the aux port, unmodified and exactly once, and never on the main port.
- R2: A word with both bits WORD_W-1 and WORD_W-2 clear (an untagged road) is presented on the main port, unmodified and exactly once, and never on the aux port.
- R3: A word with bit WORD_W-1 set (end of event) is presented exactly once on each port, whatever the value of bit WORD_W-2.
- R4: On each port, words leave in the order they were accepted at the input.
- R5: While a port holds a valid word and its ready is low, that port's valid stays high and its word stays stable. The FIFO head is kept until all ports that need it have accepted it, and a port that has already taken the head does not see it again.
- R6: The FIFO holds DEPTH words. `fifo_full_o` is high and `in_ready_o` is low when DEPTH words are stored, and input words offered while `in_ready_o` is low are not taken. `fifo_empty_o` is high when nothing is stored, and both output valids are then low.
- R7: In the cycle after an end-of-event word leaves the FIFO, `evt_tagged_o` and `evt_plain_o` show the numbers of tagged and untagged roads seen since the previous end-of-event word. Both counts saturate at 2^CNT_W-1.
- R8: After reset both valids are low, `fifo_empty_o` is high, `fifo_full_o` is low, `in_ready_o` is high and both counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | FIFO can take a word |
| in_word_i | input | WORD_W | Input road or end-of-event word |
| fifo_full_o | output | 1 | FIFO holds DEPTH words |
| fifo_empty_o | output | 1 | FIFO holds no word |
| main_valid_o | output | 1 | Regular-path word valid |
| main_ready_i | input | 1 | Regular-path consumer ready |
| main_word_o | output | WORD_W | Regular-path word |
| aux_valid_o | output | 1 | Bypass word valid |
| aux_ready_i | input | 1 | Bypass consumer ready |
| aux_word_o | output | WORD_W | Bypass word |
| evt_tagged_o | output | CNT_W | Tagged roads in the last finished event |
| evt_plain_o | output | CNT_W | Untagged roads in the last finished event |

## Verification
The hardest case to reach is an end-of-event marker at the FIFO head that one port has already taken while the other port is still stalled. In that case the head must stay in place without being shown again on the port that took it. A directed phase sets this up: it drains the FIFO, pushes a lone marker, and holds aux ready low for several cycles while main ready stays high. Random phases with independent ready patterns then reach the same case with each port in each role. A long tagged-only event drives the tagged count into saturation.

// File: rtl/road_split_pkg.sv
package road_split_pkg;
  typedef enum logic [1:0] {
    RT_MAIN = 2'b01,
    RT_AUX  = 2'b10,
    RT_BOTH = 2'b11
  } route_e;

  function automatic route_e route_of(input logic eoe, input logic tag);
    if (eoe)      return RT_BOTH;
    else if (tag) return RT_AUX;
    else          return RT_MAIN;
  endfunction
endpackage

// File: rtl/road_fifo.sv
module road_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    count_q;
  logic             do_push, do_pop;

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      if (do_push && !do_pop)      count_q <= count_q + 1'b1;
      else if (do_pop && !do_push) count_q <= count_q - 1'b1;
    end
  end
endmodule

// File: rtl/road_route.sv
module road_route
  import road_split_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic head_valid_i,
  input  logic head_eoe_i,
  input  logic head_tag_i,
  input  logic main_ready_i,
  input  logic aux_ready_i,
  output logic main_valid_o,
  output logic aux_valid_o,
  output logic pop_o
);
  route_e route;
  logic   need_main, need_aux;
  logic   sent_main_q, sent_aux_q;
  logic   main_fire, aux_fire, main_done, aux_done;

  assign route     = route_of(head_eoe_i, head_tag_i);
  assign need_main = route[0];
  assign need_aux  = route[1];

  assign main_valid_o = head_valid_i && need_main && !sent_main_q;
  assign aux_valid_o  = head_valid_i && need_aux && !sent_aux_q;
  assign main_fire    = main_valid_o && main_ready_i;
  assign aux_fire     = aux_valid_o && aux_ready_i;
  assign main_done    = !need_main || sent_main_q || main_fire;
  assign aux_done     = !need_aux || sent_aux_q || aux_fire;
  assign pop_o        = head_valid_i && main_done && aux_done;

  // remember partial delivery of a word that needs both ports
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sent_main_q <= 1'b0;
      sent_aux_q  <= 1'b0;
    end else if (pop_o) begin
      sent_main_q <= 1'b0;
      sent_aux_q  <= 1'b0;
    end else begin
      if (main_fire) sent_main_q <= 1'b1;
      if (aux_fire)  sent_aux_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/road_evt_cnt.sv
module road_evt_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pop_i,
  input  logic             eoe_i,
  input  logic             tag_i,
  output logic [CNT_W-1:0] evt_tagged_o,
  output logic [CNT_W-1:0] evt_plain_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] run_tag_q, run_plain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_tag_q    <= '0;
      run_plain_q  <= '0;
      evt_tagged_o <= '0;
      evt_plain_o  <= '0;
    end else if (pop_i) begin
      if (eoe_i) begin
        evt_tagged_o <= run_tag_q;
        evt_plain_o  <= run_plain_q;
        run_tag_q    <= '0;
        run_plain_q  <= '0;
      end else if (tag_i) begin
        if (run_tag_q != CMAX) run_tag_q <= run_tag_q + 1'b1;
      end else begin
        if (run_plain_q != CMAX) run_plain_q <= run_plain_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/road_splitter.sv
module road_splitter #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_word_i,
  output logic              fifo_full_o,
  output logic              fifo_empty_o,
  output logic              main_valid_o,
  input  logic              main_ready_i,
  output logic [WORD_W-1:0] main_word_o,
  output logic              aux_valid_o,
  input  logic              aux_ready_i,
  output logic [WORD_W-1:0] aux_word_o,
  output logic [CNT_W-1:0]  evt_tagged_o,
  output logic [CNT_W-1:0]  evt_plain_o
);
  localparam int EOE_BIT = WORD_W - 1;
  localparam int TAG_BIT = WORD_W - 2;

  logic [WORD_W-1:0] head;
  logic              pop;

  road_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (in_valid_i),
    .wdata_i (in_word_i),
    .pop_i   (pop),
    .rdata_o (head),
    .full_o  (fifo_full_o),
    .empty_o (fifo_empty_o)
  );

  road_route u_route (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .head_valid_i (!fifo_empty_o),
    .head_eoe_i   (head[EOE_BIT]),
    .head_tag_i   (head[TAG_BIT]),
    .main_ready_i (main_ready_i),
    .aux_ready_i  (aux_ready_i),
    .main_valid_o (main_valid_o),
    .aux_valid_o  (aux_valid_o),
    .pop_o        (pop)
  );

  road_evt_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pop_i        (pop),
    .eoe_i        (head[EOE_BIT]),
    .tag_i        (head[TAG_BIT]),
    .evt_tagged_o (evt_tagged_o),
    .evt_plain_o  (evt_plain_o)
  );

  assign in_ready_o  = !fifo_full_o;
  assign main_word_o = head;
  assign aux_word_o  = head;
endmodule

// File: rtl/road_splitter_chk.sv
module road_splitter_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_ready_o,
  input logic              fifo_full_o,
  input logic              fifo_empty_o,
  input logic              main_valid_o,
  input logic              main_ready_i,
  input logic [WORD_W-1:0] main_word_o,
  input logic              aux_valid_o,
  input logic              aux_ready_i,
  input logic [WORD_W-1:0] aux_word_o
);
  assert_aux_tagged_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_valid_o && !aux_word_o[WORD_W-1]) |-> aux_word_o[WORD_W-2]);

  assert_main_untagged_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_valid_o && !main_word_o[WORD_W-1]) |-> !main_word_o[WORD_W-2]);

  assert_main_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_valid_o && !main_ready_i) |=> (main_valid_o && $stable(main_word_o)));

  assert_aux_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_valid_o && !aux_ready_i) |=> (aux_valid_o && $stable(aux_word_o)));

  assert_no_take_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_full_o |-> !in_ready_o);

  assert_empty_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_empty_o |-> (!main_valid_o && !aux_valid_o));
endmodule

bind road_splitter road_splitter_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_ready_o   (in_ready_o),
  .fifo_full_o  (fifo_full_o),
  .fifo_empty_o (fifo_empty_o),
  .main_valid_o (main_valid_o),
  .main_ready_i (main_ready_i),
  .main_word_o  (main_word_o),
  .aux_valid_o  (aux_valid_o),
  .aux_ready_i  (aux_ready_i),
  .aux_word_o   (aux_word_o)
);

// File: tb/road_splitter_tb.sv
module road_splitter_tb;
  localparam int W = 32;
  localparam int DEPTH = 8;
  localparam int CNT_W = 8;
  localparam int CLK_PERIOD = 10;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, main_ready = 1'b0, aux_ready = 1'b0;
  logic [W-1:0] in_word = '0;
  logic in_ready, full, empty, main_valid, aux_valid;
  logic [W-1:0] main_word, aux_word;
  logic [CNT_W-1:0] evt_tagged, evt_plain;

  always #(CLK_PERIOD/2) clk = ~clk;

  road_splitter #(.WORD_W(W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_word_i(in_word),
    .fifo_full_o(full), .fifo_empty_o(empty),
    .main_valid_o(main_valid), .main_ready_i(main_ready), .main_word_o(main_word),
    .aux_valid_o(aux_valid), .aux_ready_i(aux_ready), .aux_word_o(aux_word),
    .evt_tagged_o(evt_tagged), .evt_plain_o(evt_plain)
  );

  int n_checks = 0, n_fail = 0;
  logic [W-1:0] q_main[$], q_aux[$];
  int q_et[$], q_ep[$];
  int run_t = 0, run_p = 0, m_eoe = 0, a_eoe = 0, done_evt = 0;
  bit pend = 0;
  int pend_t, pend_p;

  function automatic int sat_inc(int v);
    return (v >= CMAX) ? CMAX : v + 1;
  endfunction

  function automatic logic [W-1:0] mk(bit eoe, bit tag, int unsigned pl);
    logic [W-1:0] w;
    w = W'(pl);
    w[W-1] = eoe;
    w[W-2] = tag;
    return w;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_push(logic [W-1:0] w);
    if (w[W-1]) begin
      q_main.push_back(w); q_aux.push_back(w);
      q_et.push_back(run_t); q_ep.push_back(run_p);
      run_t = 0; run_p = 0;
    end else if (w[W-2]) begin
      q_aux.push_back(w); run_t = sat_inc(run_t);
    end else begin
      q_main.push_back(w); run_p = sat_inc(run_p);
    end
  endtask

  task automatic step(bit iv, logic [W-1:0] w, bit mr, bit ar);
    @(negedge clk);
    if (pend) begin
      check(int'(evt_tagged) == pend_t, "R7 tagged count", evt_tagged, pend_t);
      check(int'(evt_plain) == pend_p, "R7 plain count", evt_plain, pend_p);
      pend = 0;
    end
    in_valid = iv; in_word = w; main_ready = mr; aux_ready = ar;
    #1;
    if (main_valid && main_ready) begin
      if (q_main.size() == 0) check(0, "R2/R3 unexpected main word", main_word, 0);
      else begin
        check(main_word == q_main[0], "R2/R3/R4 main word", main_word, q_main[0]);
        if (main_word[W-1]) m_eoe++;
        void'(q_main.pop_front());
      end
    end
    if (aux_valid && aux_ready) begin
      if (q_aux.size() == 0) check(0, "R1/R3 unexpected aux word", aux_word, 0);
      else begin
        check(aux_word == q_aux[0], "R1/R3/R4 aux word", aux_word, q_aux[0]);
        if (aux_word[W-1]) a_eoe++;
        void'(q_aux.pop_front());
      end
    end
    if (done_evt < m_eoe && done_evt < a_eoe && q_et.size() > 0) begin
      done_evt++;
      pend_t = q_et.pop_front(); pend_p = q_ep.pop_front();
      pend = 1;
    end
    if (in_valid && in_ready) model_push(in_word);
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && !(q_main.size() == 0 && q_aux.size() == 0 && !pend); i++)
      step(0, '0, 1, 1);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R8 reset state
    check(!main_valid && !aux_valid, "R8 valids", {main_valid, aux_valid}, 0);
    check(empty && !full && in_ready, "R8 fifo status", {empty, full, in_ready}, 3'b101);
    check(evt_tagged == 0 && evt_plain == 0, "R8 counts", {evt_tagged, evt_plain}, 0);

    // R6 fill to full with both ports stalled; extra offers must be refused
    for (int i = 0; i < DEPTH + 3; i++) step(1, mk(0, i[0], i + 1), 0, 0);
    @(negedge clk); #1;
    check(full && !in_ready, "R6 full", {full, in_ready}, 2'b10);
    check(q_main.size() + q_aux.size() == DEPTH, "R6 stored count",
          q_main.size() + q_aux.size(), DEPTH);
    step(1, mk(1, 0, 77), 1, 1);
    drain();
    @(negedge clk); #1;
    check(empty && !main_valid && !aux_valid, "R6 empty after drain", {empty, main_valid, aux_valid}, 3'b100);

    // R5/R3 lone end-of-event, aux stalled after main has taken it
    step(1, mk(1, 1, 55), 0, 0);
    for (int i = 0; i < 4; i++) step(0, '0, 1, 0);
    check(aux_valid && !main_valid && !empty, "R5 head held, main not repeated",
          {aux_valid, main_valid, empty}, 3'b100);
    drain();
    // R5 mirror: main stalled after aux took it
    step(1, mk(1, 0, 56), 0, 0);
    for (int i = 0; i < 4; i++) step(0, '0, 0, 1);
    check(main_valid && !aux_valid && !empty, "R5 head held, aux not repeated",
          {main_valid, aux_valid, empty}, 3'b100);
    drain();

    // R7 saturation: long tagged-only event, then an empty event
    for (int i = 0; i < CMAX + 40; i++) step(1, mk(0, 1, i), 1, 1);
    step(1, mk(1, 0, 1), 1, 1);
    step(1, mk(1, 0, 2), 1, 1);
    drain();
    check(evt_tagged == 0 && evt_plain == 0, "R7 empty event counts", {evt_tagged, evt_plain}, 0);

    // R1-R4 random traffic with varied ready patterns
    for (int ph = 0; ph < 4; ph++) begin
      for (int i = 0; i < 1500; i++) begin
        bit iv, mr, ar, eoe, tag;
        iv  = ($urandom % 100) < 75;
        eoe = ($urandom % 100) < 12;
        tag = ($urandom % 100) < 45;
        mr  = ($urandom % 100) < ((ph == 1) ? 25 : 70);
        ar  = ($urandom % 100) < ((ph == 2) ? 25 : 70);
        step(iv, mk(eoe, tag, $urandom), mr, ar);
      end
      step(1, mk(1, 0, ph), 1, 1);
      drain();
    end
    check(q_main.size() == 0 && q_aux.size() == 0, "R4 all words delivered",
          q_main.size() + q_aux.size(), 0);
    @(negedge clk); #1;
    check(empty, "R6 empty at end", empty, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule